// File: doc/BRIEF.md
# Peripheral Register Front-End with Masked Interrupt Source

This block is the register face of one peripheral on a 32-bit word bus. It has five registers. The command register is write-only and gives one single-cycle strobe for each bit written as one. The mode register is a plain read/write configuration word. The status register can only be read from the bus; the peripheral's own hardware sets and clears its bits through side inputs. The interrupt mask can be read back, but a bus write never loads it directly.

The mask changes only through two write-only addresses. A one written to the enable address sets the matching mask bit. A one written to the disable address clears it. Software can therefore change any group of mask bits with one bus write and no read-modify-write. The block drives a level interrupt-source output, which is high when any status bit is set and its mask bit is also set.

The bus is synchronous. Reads return data in the cycle after the read strobe. The two lowest address bits are ignored, so every access is treated as a word access. Register word offsets: 0 command, 1 mode, 2 status, 3 mask enable, 4 mask disable, 5 mask readback.

Top module: `perif_regfront`

## Requirements
- R1: Address bits [1:0] are ignored. An access at any byte address inside a word reaches the same register as the aligned address.
- R2: A write to word offset 3 sets each mask bit whose write-data bit is one. Mask bits with a zero in the write data keep their value.
- R3: A write to word offset 4 clears each mask bit whose write-data bit is one. Mask bits with a zero in the write data keep their value.
- R4: A read of word offset 5 returns the mask in bits [NSRC-1:0]. The mask resets to zero. Bus writes to offset 5 have no effect.
- R5: `irq_o` is high exactly when (status AND mask) has at least one bit set. It is evaluated on the registered state.
- R6: A write to word offset 0 drives `cmd_o` to write-data bits [NCMD-1:0] for exactly one cycle, the cycle after the write edge. Zero bits give no strobe, and `cmd_o` is zero at all other times.
- R7: The mode register at word offset 1 is read/write and resets to zero. Only bits [NMODE-1:0] are stored; the other bits read as zero. `mode_o` shows the stored value.
- R8: The status register at word offset 2 ignores bus writes. On each clock it takes (status AND NOT `stat_clr_i`) OR `stat_set_i`, so a set wins over a clear of the same bit.
- R9: Reads of the write-only offsets 0, 3 and 4, and of every offset other than 0 to 5, return zero.
- R10: `mask_clr_i` clears mask bits in hardware. If a clear from this input or from offset 4 hits the same bit as an enable write in the same cycle, the clear wins.
- R11: `rdata_o` holds the value read in the cycle after `rd_en_i` is high, and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| cmd_o | output | NCMD | One-cycle command strobes |
| mode_o | output | NMODE | Current mode register |
| stat_set_i | input | NSRC | Hardware status set requests |
| stat_clr_i | input | NSRC | Hardware status clear requests |
| mask_clr_i | input | NSRC | Hardware mask clear, wins over enable |
| irq_o | output | 1 | Level interrupt source |

## Verification
The bench aims at the cases where priorities decide the result. One is an enable write that lands in the same cycle as a hardware mask clear; a design that lets the enable win would leave the bit set and keep the interrupt high. Another is a status bit that is set and cleared in the same cycle; a design that favours the clear would lose that event. It also writes to the read-only status and mask offsets, writes mode bits above the stored width, and uses unaligned byte addresses. A design that decodes the low address bits, stores the unused bits or lets those writes through gives read data that differs from the model. Finally it checks that command strobes last exactly one cycle and that reads of write-only or undecoded offsets return zero. A stretched pulse, or a read path that leaks the last write, shows up there.

// File: rtl/regfront_pkg.sv
package regfront_pkg;

    localparam int BUS_W = 32;

    // word offsets; software depends on these positions
    localparam int OFS_CMD  = 0;
    localparam int OFS_MODE = 1;
    localparam int OFS_STAT = 2;
    localparam int OFS_MEN  = 3;
    localparam int OFS_MDIS = 4;
    localparam int OFS_MRD  = 5;

    typedef struct packed {
        logic cmd;
        logic mode;
        logic stat;
        logic men;
        logic mdis;
        logic mrd;
    } sel_t;

endpackage

// File: rtl/regfront_decode.sv
module regfront_decode
    import regfront_pkg::*;
#(
    parameter int WIDX_W = 6
) (
    input  logic [WIDX_W-1:0] widx_i,
    output sel_t              sel_o
);

    always_comb begin
        sel_o      = '0;
        sel_o.cmd  = (widx_i == WIDX_W'(OFS_CMD));
        sel_o.mode = (widx_i == WIDX_W'(OFS_MODE));
        sel_o.stat = (widx_i == WIDX_W'(OFS_STAT));
        sel_o.men  = (widx_i == WIDX_W'(OFS_MEN));
        sel_o.mdis = (widx_i == WIDX_W'(OFS_MDIS));
        sel_o.mrd  = (widx_i == WIDX_W'(OFS_MRD));
    end

endmodule

// File: rtl/regfront_mask.sv
module regfront_mask #(
    parameter int NSRC = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_we_i,
    input  logic            dis_we_i,
    input  logic [NSRC-1:0] bits_i,
    input  logic [NSRC-1:0] hw_clr_i,
    output logic [NSRC-1:0] mask_o
);

    typedef struct packed {
        logic [NSRC-1:0] mask;
    } mstate_t;

    mstate_t         st_d, st_q;
    logic [NSRC-1:0] set_bits, clr_bits;

    always_comb begin
        set_bits = en_we_i  ? bits_i : '0;
        clr_bits = (dis_we_i ? bits_i : '0) | hw_clr_i;
        st_d     = st_q;
        // clear applied last: it wins over a same-bit enable
        st_d.mask = (st_q.mask | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    p_enable_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_we_i |=> ((mask_o & $past(bits_i & ~clr_bits)) == $past(bits_i & ~clr_bits)));

    p_clear_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_bits != '0) |=> ((mask_o & $past(clr_bits)) == '0));

    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_we_i && clr_bits == '0) |=> $stable(mask_o));

endmodule

// File: rtl/regfront_status.sv
module regfront_status #(
    parameter int NSRC = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] status_o
);

    typedef struct packed {
        logic [NSRC-1:0] bits;
    } sstate_t;

    sstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NSRC; i++) begin
            if (set_i[i])      st_d.bits[i] = 1'b1;
            else if (clr_i[i]) st_d.bits[i] = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.bits;

    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    p_quiet_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i == '0 && clr_i == '0) |=> $stable(status_o));

endmodule

// File: rtl/perif_regfront.sv
module perif_regfront
    import regfront_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCMD   = 4,
    parameter int NMODE  = 6,
    parameter int NSRC   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic              rd_en_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [NCMD-1:0]   cmd_o,
    output logic [NMODE-1:0]  mode_o,
    input  logic [NSRC-1:0]   stat_set_i,
    input  logic [NSRC-1:0]   stat_clr_i,
    input  logic [NSRC-1:0]   mask_clr_i,
    output logic              irq_o
);

    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [NMODE-1:0] mode;
        logic [NCMD-1:0]  cmd;
        logic [BUS_W-1:0] rdata;
    } tstate_t;

    tstate_t         st_d, st_q;
    sel_t            sel;
    logic [NSRC-1:0] mask, status;
    logic [WIDX_W-1:0] widx;
    logic            unused_bits;

    assign widx        = addr_i[ADDR_W-1:2];
    assign unused_bits = ^{addr_i[1:0], wdata_i};

    regfront_decode #(.WIDX_W(WIDX_W)) u_dec (
        .widx_i (widx),
        .sel_o  (sel)
    );

    regfront_mask #(.NSRC(NSRC)) u_mask (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_we_i  (we_i && sel.men),
        .dis_we_i (we_i && sel.mdis),
        .bits_i   (wdata_i[NSRC-1:0]),
        .hw_clr_i (mask_clr_i),
        .mask_o   (mask)
    );

    regfront_status #(.NSRC(NSRC)) u_stat (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (stat_set_i),
        .clr_i    (stat_clr_i),
        .status_o (status)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cmd   = (we_i && sel.cmd) ? wdata_i[NCMD-1:0] : '0;
        if (we_i && sel.mode) st_d.mode = wdata_i[NMODE-1:0];
        st_d.rdata = '0;
        if (rd_en_i) begin
            unique case (1'b1)
                sel.mode: st_d.rdata = BUS_W'(st_q.mode);
                sel.stat: st_d.rdata = BUS_W'(status);
                sel.mrd:  st_d.rdata = BUS_W'(mask);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;
    assign cmd_o   = st_q.cmd;
    assign mode_o  = st_q.mode;
    assign irq_o   = |(status & mask);

    p_cmd_origin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o != '0) |-> $past(we_i && sel.cmd));

    p_rdata_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(rd_en_i) |-> (rdata_o == '0));

    p_mode_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && sel.mode) |=> $stable(mode_o));

endmodule

// File: tb/tb_perif_regfront.sv
`timescale 1ns/1ps
module tb_perif_regfront;

    localparam int ADDR_W = 8;
    localparam int NCMD   = 4;
    localparam int NMODE  = 6;
    localparam int NSRC   = 8;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              we = 1'b0, rd = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NCMD-1:0]   cmd;
    logic [NMODE-1:0]  mode;
    logic [NSRC-1:0]   sset = '0, sclr = '0, mclr = '0;
    logic              irq;

    int checks = 0;
    int errors = 0;

    logic [NSRC-1:0]  m_mask = '0, m_stat = '0;
    logic [NMODE-1:0] m_mode = '0;

    always #5 clk = ~clk;

    perif_regfront #(.ADDR_W(ADDR_W), .NCMD(NCMD), .NMODE(NMODE), .NSRC(NSRC)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .rd_en_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .cmd_o(cmd), .mode_o(mode),
        .stat_set_i(sset), .stat_clr_i(sclr), .mask_clr_i(mclr), .irq_o(irq)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input int w);
        case (w)
            1:       return 32'(m_mode);
            2:       return 32'(m_stat);
            5:       return 32'(m_mask);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input int w);
        case (w)
            0, 3, 4: return "R9(write-only)";
            1:       return "R7";
            2:       return "R8";
            5:       return "R4";
            default: return "R9(undecoded)";
        endcase
    endfunction

    // one bus cycle: drive at a falling edge, check at the next falling edge
    task automatic step(input bit w_en, input bit r_en, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic [NSRC-1:0] s,
                        input logic [NSRC-1:0] c, input logic [NSRC-1:0] mc,
                        input string note);
        int               w = int'(a[ADDR_W-1:2]);
        logic [31:0]      exp_rd;
        logic [NCMD-1:0]  exp_cmd;
        logic [NSRC-1:0]  setb, clrb;
        string            tg;
        we = w_en; rd = r_en; addr = a; wdata = d; sset = s; sclr = c; mclr = mc;
        exp_rd  = r_en ? model_read(w) : 32'h0;
        exp_cmd = (w_en && w == 0) ? d[NCMD-1:0] : '0;
        tg      = r_en ? read_tag(w) : "R11";
        setb    = (w_en && w == 3) ? d[NSRC-1:0] : '0;
        clrb    = ((w_en && w == 4) ? d[NSRC-1:0] : '0) | mc;
        m_mask  = (m_mask | setb) & ~clrb;          // R2 R3 R10
        m_stat  = (m_stat & ~c) | s;                // R8 set wins
        if (w_en && w == 1) m_mode = d[NMODE-1:0];  // R7
        @(negedge clk);
        we = 1'b0; rd = 1'b0; sset = '0; sclr = '0; mclr = '0;
        check(rdata === exp_rd, tg, {note, " rdata"}, rdata, exp_rd);
        check(cmd === exp_cmd, "R6", {note, " cmd strobe"}, 32'(cmd), 32'(exp_cmd));
        check(mode === m_mode, "R7", {note, " mode_o"}, 32'(mode), 32'(m_mode));
        check(irq === |(m_stat & m_mask), "R5", {note, " irq"}, 32'(irq), 32'(|(m_stat & m_mask)));
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string n);
        step(1'b1, 1'b0, a, d, '0, '0, '0, n);
    endtask

    task automatic rdc(input logic [ADDR_W-1:0] a, input string n);
        step(1'b0, 1'b1, a, 32'h0, '0, '0, '0, n);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        // reset state: R4 mask zero, R7 mode zero, R5 irq low
        rdc(8'h14, "reset mask R4");
        rdc(8'h04, "reset mode R7");
        rdc(8'h08, "reset status R8");
        // R7 unused bits read zero
        wr(8'h04, 32'hFFFF_FFFF, "mode all ones R7");
        rdc(8'h04, "mode readback R7");
        // R1 unaligned byte addresses
        wr(8'h07, 32'h0000_0015, "mode unaligned write R1");
        rdc(8'h06, "mode unaligned read R1");
        // R2 / R3 set and clear groups
        wr(8'h0C, 32'h0F, "enable low nibble R2");
        rdc(8'h14, "mask after enable R2");
        wr(8'h0D, 32'h30, "enable more unaligned R2 R1");
        rdc(8'h14, "mask after second enable R2");
        wr(8'h10, 32'h05, "disable bits R3");
        rdc(8'h14, "mask after disable R3");
        // R4 write to mask readback ignored
        wr(8'h14, 32'hFF, "write mask readback R4");
        rdc(8'h14, "mask unchanged R4");
        // R8 bus write to status ignored; set wins
        wr(8'h08, 32'hFF, "write status R8");
        rdc(8'h08, "status still zero R8");
        step(1'b0, 1'b0, 8'h0, 32'h0, 8'h0A, 8'h0A, '0, "set+clr same bit R8");
        rdc(8'h08, "status after set wins R8");
        // R10 hardware clear beats enable
        step(1'b1, 1'b0, 8'h0C, 32'h80, '0, '0, 8'h80, "enable vs hw clear R10");
        rdc(8'h14, "mask bit7 cleared R10");
        // R6 command pulse lasts one cycle; R9 reads of write-only
        wr(8'h00, 32'h0000_0005, "command strobe R6");
        step(1'b0, 1'b0, 8'h0, 32'h0, '0, '0, '0, "strobe gone R6");
        rdc(8'h00, "read command R9");
        rdc(8'h0C, "read enable R9");
        rdc(8'h10, "read disable R9");
        rdc(8'h1C, "read undecoded R9");
        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r = $urandom;
            logic [ADDR_W-1:0] a = {2'b00, 4'($urandom_range(0, 9)), r[1:0]};
            step(r[2], r[3], a, $urandom,
                 NSRC'($urandom & $urandom & $urandom),
                 NSRC'($urandom & $urandom),
                 r[8] ? NSRC'($urandom & $urandom & $urandom) : '0,
                 "random");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule